// File: doc/BRIEF.md
# Pipelined Pre-Add Multiply-Accumulate Slice

This block is a signed arithmetic slice of the kind that sits in filter taps and accumulator chains. It first combines two 25-bit operands in a pre-adder, adding or subtracting them. It multiplies that sum by an 18-bit operand. A three-input ALU step then merges the product with a selectable third operand into a 48-bit result. The third operand can be zero, a cascade input from a neighbouring slice, the slice's own previous result, or a 48-bit addend.

A 5-bit mode word travels down the pipeline with its operands, so every operation can use a different mode. Neighbouring slices are chained by wiring the full-width result of one slice to the cascade input of the next. Running sums are formed by selecting the slice's own result as the third operand, and a sum is restarted by selecting the addend instead. The visible result drops a parameterised number of low bits.

The pipeline has four stages:
1. Input capture of the operands and the mode.
2. The pre-adder result, together with the delayed addend and mode.
3. The product register.
4. The result register.

There is no control state machine. Every stage advances under its own clock enable.

Top module: `mac_slice`

## Requirements
- R1: Mode bit 4 selects the pre-adder sign. When it is 0 the pre-add result is A+D; when it is 1 it is A−D. A and D are 25-bit signed and the pre-add result is 26-bit signed.
- R2: Mode bits [3:2] select the third operand Z: 0 is zero, 1 is the cascade input sampled in the cycle the result register loads, 2 is the slice's own current result, and 3 is the C operand presented with the vector.
- R3: Mode bits [1:0] select the ALU form, where M is the sign-extended product (pre-add result × B): 0 gives Z+M, 1 gives M−Z, 2 gives −(Z+M+1), and 3 gives Z−M.
- R4: With all clock enables high, the result for a vector sampled at clock edge k is present after edge k+3. Back-to-back vectors produce back-to-back results.
- R5: The cascade output carries the full 48-bit result. The visible result is bits [47:S] of it, where S is a parameter.
- R6: All 48-bit arithmetic wraps modulo 2^48, without saturation.
- R7: A synchronous reset clears every pipeline register, including the result, to zero.
- R8: While the result enable is low, the result holds its value whatever the mode and operands are.
- R9: While the first-stage A and B enables are low, the first stage keeps its operands and mode. Later results are then computed from the held vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_a1 | input | 1 | Enable for first A stage, D and mode capture |
| ce_a2 | input | 1 | Enable for the pre-adder register |
| ce_b1 | input | 1 | Enable for first B stage |
| ce_b2 | input | 1 | Enable for second B stage |
| ce_c | input | 1 | Enable for the C delay stages |
| ce_m | input | 1 | Enable for the product stage |
| ce_p | input | 1 | Enable for the result register |
| mode | input | 5 | {pre-sub, Z select[1:0], ALU form[1:0]} |
| a_in | input | 25 | Signed pre-adder operand A |
| d_in | input | 25 | Signed pre-adder operand D |
| b_in | input | 18 | Signed multiplier operand B |
| c_in | input | 48 | Signed addend C |
| pc_in | input | 48 | Cascade input from a neighbour |
| pc_out | output | 48 | Full result, for cascading |
| p_out | output | 48−S | Result bits [47:S] |

## Verification
The critical collision is a fresh product reaching the ALU in the same cycle as the result it must combine with. The other party is either the slice's own previous result, when Z selects the accumulator, or the cascade input, which is sampled only in that cycle. The bench streams one vector per cycle through all 32 modes and ends with a restart-then-accumulate run. Every accumulate step therefore consumes the result written one cycle earlier, and every cascade step consumes the value driven three cycles after its operands. Each result is compared against a running arithmetic model that applies the same feedback and cascade timing.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;

    typedef enum logic [1:0] {
        Z_ZERO = 2'd0,
        Z_CASC = 2'd1,
        Z_SELF = 2'd2,
        Z_CREG = 2'd3
    } zsrc_t;

    typedef enum logic [1:0] {
        OP_ADD     = 2'd0,
        OP_NEG_Z   = 2'd1,
        OP_NEG_ALL = 2'd2,
        OP_SUB     = 2'd3
    } aluop_t;

    typedef struct packed {
        logic   presub;
        zsrc_t  zsrc;
        aluop_t op;
    } mode_t;

endpackage

// File: rtl/mac_preadd_stage.sv
module mac_preadd_stage
    import mac_slice_pkg::*;
#(
    parameter int AW = 25,
    parameter int BW = 18,
    parameter int PW = 48,
    localparam int ADW = AW + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce_a1,
    input  logic                  ce_a2,
    input  logic                  ce_b1,
    input  logic                  ce_b2,
    input  logic                  ce_c,
    input  mode_t                 mode_in,
    input  logic signed [AW-1:0]  a_in,
    input  logic signed [AW-1:0]  d_in,
    input  logic signed [BW-1:0]  b_in,
    input  logic signed [PW-1:0]  c_in,
    output logic signed [ADW-1:0] ad_s2,
    output logic signed [BW-1:0]  b_s2,
    output logic signed [PW-1:0]  c_s2,
    output mode_t                 mode_s2
);

    logic signed [AW-1:0]  a_s1, d_s1;
    logic signed [BW-1:0]  b_s1;
    logic signed [PW-1:0]  c_s1;
    mode_t                 mode_s1;
    logic signed [ADW-1:0] ad_next;

    // stage 1: input capture
    always_ff @(posedge clk) begin
        if (rst) begin
            a_s1    <= '0;
            d_s1    <= '0;
            b_s1    <= '0;
            c_s1    <= '0;
            mode_s1 <= '0;
        end else begin
            if (ce_a1) begin
                a_s1    <= a_in;
                d_s1    <= d_in;
                mode_s1 <= mode_in;
            end
            if (ce_b1) b_s1 <= b_in;
            if (ce_c)  c_s1 <= c_in;
        end
    end

    always_comb begin
        if (mode_s1.presub)
            ad_next = $signed({a_s1[AW-1], a_s1}) - $signed({d_s1[AW-1], d_s1});
        else
            ad_next = $signed({a_s1[AW-1], a_s1}) + $signed({d_s1[AW-1], d_s1});
    end

    // stage 2: pre-adder result
    always_ff @(posedge clk) begin
        if (rst) begin
            ad_s2   <= '0;
            b_s2    <= '0;
            c_s2    <= '0;
            mode_s2 <= '0;
        end else begin
            if (ce_a2) begin
                ad_s2   <= ad_next;
                mode_s2 <= mode_s1;
            end
            if (ce_b2) b_s2 <= b_s1;
            if (ce_c)  c_s2 <= c_s1;
        end
    end

endmodule

// File: rtl/mac_mult_stage.sv
module mac_mult_stage
    import mac_slice_pkg::*;
#(
    parameter int AW = 25,
    parameter int BW = 18,
    parameter int PW = 48,
    localparam int ADW = AW + 1,
    localparam int MW  = ADW + BW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce_m,
    input  logic                  ce_c,
    input  logic signed [ADW-1:0] ad_s2,
    input  logic signed [BW-1:0]  b_s2,
    input  logic signed [PW-1:0]  c_s2,
    input  mode_t                 mode_s2,
    output logic signed [PW-1:0]  m_ext,
    output logic signed [PW-1:0]  c_s3,
    output zsrc_t                 zsrc_s3,
    output aluop_t                op_s3
);

    logic signed [MW-1:0] m_s3;

    // stage 3: product register
    always_ff @(posedge clk) begin
        if (rst) begin
            m_s3    <= '0;
            c_s3    <= '0;
            zsrc_s3 <= Z_ZERO;
            op_s3   <= OP_ADD;
        end else begin
            if (ce_m) begin
                m_s3    <= ad_s2 * b_s2;
                zsrc_s3 <= mode_s2.zsrc;
                op_s3   <= mode_s2.op;
            end
            if (ce_c) c_s3 <= c_s2;
        end
    end

    assign m_ext = {{(PW-MW){m_s3[MW-1]}}, m_s3};

endmodule

// File: rtl/mac_alu_stage.sv
module mac_alu_stage
    import mac_slice_pkg::*;
#(
    parameter int PW = 48
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce_p,
    input  zsrc_t                zsrc_s3,
    input  aluop_t               op_s3,
    input  logic signed [PW-1:0] m_ext,
    input  logic signed [PW-1:0] c_s3,
    input  logic signed [PW-1:0] pc_in,
    output logic signed [PW-1:0] p_reg
);

    logic signed [PW-1:0] z_op;
    logic signed [PW-1:0] p_next;

    always_comb begin
        unique case (zsrc_s3)
            Z_ZERO: z_op = '0;
            Z_CASC: z_op = pc_in;
            Z_SELF: z_op = p_reg;
            Z_CREG: z_op = c_s3;
        endcase
    end

    always_comb begin
        unique case (op_s3)
            OP_ADD:     p_next = z_op + m_ext;
            OP_NEG_Z:   p_next = m_ext - z_op;
            OP_NEG_ALL: p_next = ~(z_op + m_ext);
            OP_SUB:     p_next = z_op - m_ext;
        endcase
    end

    // stage 4: result register
    always_ff @(posedge clk) begin
        if (rst)       p_reg <= '0;
        else if (ce_p) p_reg <= p_next;
    end

endmodule

// File: rtl/mac_slice.sv
module mac_slice
    import mac_slice_pkg::*;
#(
    parameter int AW = 25,
    parameter int BW = 18,
    parameter int PW = 48,
    parameter int S  = 0,
    localparam int ADW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_a1,
    input  logic          ce_a2,
    input  logic          ce_b1,
    input  logic          ce_b2,
    input  logic          ce_c,
    input  logic          ce_m,
    input  logic          ce_p,
    input  logic [4:0]    mode,
    input  logic [AW-1:0] a_in,
    input  logic [AW-1:0] d_in,
    input  logic [BW-1:0] b_in,
    input  logic [PW-1:0] c_in,
    input  logic [PW-1:0] pc_in,
    output logic [PW-1:0] pc_out,
    output logic [PW-1-S:0] p_out
);

    logic signed [ADW-1:0] ad_s2;
    logic signed [BW-1:0]  b_s2;
    logic signed [PW-1:0]  c_s2, c_s3, m_ext, p_reg;
    mode_t                 mode_s2;
    zsrc_t                 zsrc_s3;
    aluop_t                op_s3;

    mac_preadd_stage #(.AW(AW), .BW(BW), .PW(PW)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .ce_a1   (ce_a1),
        .ce_a2   (ce_a2),
        .ce_b1   (ce_b1),
        .ce_b2   (ce_b2),
        .ce_c    (ce_c),
        .mode_in (mode_t'(mode)),
        .a_in    ($signed(a_in)),
        .d_in    ($signed(d_in)),
        .b_in    ($signed(b_in)),
        .c_in    ($signed(c_in)),
        .ad_s2   (ad_s2),
        .b_s2    (b_s2),
        .c_s2    (c_s2),
        .mode_s2 (mode_s2)
    );

    mac_mult_stage #(.AW(AW), .BW(BW), .PW(PW)) u_mul (
        .clk     (clk),
        .rst     (rst),
        .ce_m    (ce_m),
        .ce_c    (ce_c),
        .ad_s2   (ad_s2),
        .b_s2    (b_s2),
        .c_s2    (c_s2),
        .mode_s2 (mode_s2),
        .m_ext   (m_ext),
        .c_s3    (c_s3),
        .zsrc_s3 (zsrc_s3),
        .op_s3   (op_s3)
    );

    mac_alu_stage #(.PW(PW)) u_alu (
        .clk     (clk),
        .rst     (rst),
        .ce_p    (ce_p),
        .zsrc_s3 (zsrc_s3),
        .op_s3   (op_s3),
        .m_ext   (m_ext),
        .c_s3    (c_s3),
        .pc_in   ($signed(pc_in)),
        .p_reg   (p_reg)
    );

    assign pc_out = p_reg;
    assign p_out  = p_reg[PW-1:S];

endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk #(
    parameter int PW = 48
) (
    input logic          clk,
    input logic          rst,
    input logic          ce_p,
    input logic [1:0]    zsrc,
    input logic [1:0]    op,
    input logic [PW-1:0] m_ext,
    input logic [PW-1:0] pcout
);

    // R7
    rst_clears_chk: assert property (@(posedge clk) rst |=> pcout == '0);

    // R8
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ce_p |=> pcout == $past(pcout));

    // R3
    plain_product_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_p && zsrc == 2'd0 && op == 2'd0) |=> pcout == $past(m_ext));

    // R3
    ones_compl_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_p && zsrc == 2'd0 && op == 2'd2) |=> pcout == ~$past(m_ext));

    // R2
    accum_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_p && zsrc == 2'd2 && op == 2'd0 && m_ext == '0) |=> pcout == $past(pcout));

endmodule

bind mac_slice mac_slice_chk #(.PW(PW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .ce_p  (ce_p),
    .zsrc  (zsrc_s3),
    .op    (op_s3),
    .m_ext (m_ext),
    .pcout (pc_out)
);

// File: tb/mac_slice_bench.sv
module mac_slice_bench;

    localparam int CLK_PERIOD = 10;
    localparam int S_B  = 4;
    localparam int NVEC = 200;

    logic        clk = 1'b0;
    logic        rst;
    logic        ce_a1, ce_a2, ce_b1, ce_b2, ce_c, ce_m, ce_p;
    logic [4:0]  mode;
    logic [24:0] a_in, d_in;
    logic [17:0] b_in;
    logic [47:0] c_in, pc_in;
    logic [47:0] pc_out;
    logic [47-S_B:0] p_out;

    logic [4:0]  v_mode [NVEC];
    logic [24:0] v_a    [NVEC];
    logic [24:0] v_d    [NVEC];
    logic [17:0] v_b    [NVEC];
    logic [47:0] v_c    [NVEC];
    logic [47:0] v_pc   [NVEC+4];

    int nvec = 0;
    int nfail = 0;
    logic signed [47:0] prev_p, exp_p;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_slice #(.S(S_B)) u_mac_slice (
        .clk(clk), .rst(rst),
        .ce_a1(ce_a1), .ce_a2(ce_a2), .ce_b1(ce_b1), .ce_b2(ce_b2),
        .ce_c(ce_c), .ce_m(ce_m), .ce_p(ce_p),
        .mode(mode), .a_in(a_in), .d_in(d_in), .b_in(b_in),
        .c_in(c_in), .pc_in(pc_in), .pc_out(pc_out), .p_out(p_out)
    );

    function automatic logic [31:0] mix(input int unsigned i, input int unsigned k);
        logic [31:0] x;
        x = (i * 32'h9E3779B1) ^ ((k + 1) * 32'h85EBCA77);
        x = x ^ (x >> 15);
        x = x * 32'h2C1B3C6D;
        x = x ^ (x >> 12);
        return x;
    endfunction

    function automatic logic signed [47:0] ref_p(
        input logic [4:0] md,
        input logic signed [24:0] a, input logic signed [24:0] d,
        input logic signed [17:0] b, input logic signed [47:0] c,
        input logic signed [47:0] zc, input logic signed [47:0] pp);
        logic signed [25:0] ad;
        logic signed [47:0] m, z, r;
        ad = md[4] ? (26'(a) - 26'(d)) : (26'(a) + 26'(d));
        m  = 48'(ad) * 48'(b);
        case (md[3:2])
            2'd0: z = '0;
            2'd1: z = zc;
            2'd2: z = pp;
            default: z = c;
        endcase
        case (md[1:0])
            2'd0: r = z + m;
            2'd1: r = m - z;
            2'd2: r = -(z + m + 48'sd1);
            default: r = z - m;
        endcase
        return r;
    endfunction

    task automatic chk(input string tag, input logic [47:0] exp);
        nvec++;
        if (pc_out !== exp || p_out !== exp[47:S_B]) begin
            nfail++;
            $display("FAIL %s: pc_out=%h p_out=%h expected %h", tag, pc_out, p_out, exp);
        end
    endtask

    task automatic drive_vec(input int n);
        if (n < NVEC) begin
            mode = v_mode[n]; a_in = v_a[n]; d_in = v_d[n];
            b_in = v_b[n]; c_in = v_c[n];
        end else begin
            mode = '0; a_in = '0; d_in = '0; b_in = '0; c_in = '0;
        end
        pc_in = v_pc[n];
    endtask

    task automatic set_ce(input logic v);
        ce_a1 = v; ce_a2 = v; ce_b1 = v; ce_b2 = v; ce_c = v; ce_m = v; ce_p = v;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nfail++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NVEC + 4; i++) begin
            if (i < NVEC) begin
                if (i < 192)       v_mode[i] = 5'(i % 32);
                else if (i == 192) v_mode[i] = 5'b01100;
                else               v_mode[i] = 5'b01000;
                if (i % 6 == 0) begin
                    v_a[i] = 25'h1000000;
                    v_d[i] = 25'h0FFFFFF;
                    v_b[i] = 18'h20000;
                    v_c[i] = 48'h7FFF_FFFF_FFFF;
                end else begin
                    v_a[i] = mix(i, 0)[24:0];
                    v_d[i] = mix(i, 1)[24:0];
                    v_b[i] = (i % 6 == 3) ? 18'h0 : mix(i, 2)[17:0];
                    v_c[i] = {mix(i, 3)[15:0], mix(i, 4)};
                end
                v_pc[i] = {mix(i, 5)[15:0], mix(i, 6)};
            end else begin
                v_pc[i] = '0;
            end
        end

        // R7: reset with busy inputs
        rst = 1'b1;
        set_ce(1'b1);
        drive_vec(5);
        repeat (3) @(negedge clk);
        chk("R7 reset", 48'h0);
        rst = 1'b0;
        drive_vec(NVEC);

        // R1 R2 R3 R4 R5 R6: back-to-back stream over all modes
        prev_p = '0;
        for (int n = 0; n < NVEC + 4; n++) begin
            @(negedge clk);
            if (n >= 1) begin
                if (n - 1 >= 3) begin
                    exp_p = ref_p(v_mode[n-4], v_a[n-4], v_d[n-4], v_b[n-4],
                                  v_c[n-4], v_pc[n-1], prev_p);
                    chk($sformatf("R1/R2/R3/R4/R5/R6 vec %0d mode %0d", n-4, v_mode[n-4]), exp_p);
                end else begin
                    exp_p = '0;
                    chk("R4 pipeline fill", exp_p);
                end
                prev_p = exp_p;
            end
            drive_vec(n);
        end

        // R8: load 12345+(3+4)*5 then freeze result register
        mode = 5'b01100; a_in = 25'd3; d_in = 25'd4; b_in = 18'd5;
        c_in = 48'd12345; pc_in = '0;
        @(negedge clk);
        mode = '0; a_in = '0; d_in = '0; b_in = '0; c_in = '0;
        repeat (3) @(negedge clk);
        chk("R8 preload", 48'd12380);
        ce_p = 1'b0;
        mode = 5'b01000; a_in = 25'd100; d_in = 25'd7; b_in = 18'd9; c_in = 48'd5;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R8 hold", 48'd12380);
        end
        ce_p = 1'b1;

        // R9: hold first stage on (7 + -2) * -3 = -15
        mode = 5'b00000; a_in = 25'd7; d_in = -25'sd2; b_in = -18'sd3; c_in = '0;
        @(negedge clk);
        ce_a1 = 1'b0; ce_b1 = 1'b0;
        mode = 5'b01000; a_in = 25'd999; d_in = 25'd1; b_in = 18'd77;
        repeat (5) @(negedge clk);
        chk("R9 held vector", -48'sd15);
        @(negedge clk);
        chk("R9 held vector", -48'sd15);

        // R7: mid-run reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R7 mid-run reset", 48'h0);
        @(negedge clk);
        chk("R7 after reset", 48'h0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule